// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Engine

This block moves one byte at a time over a three-wire synchronous link (serial clock out, data out, data in) as the clock master. A byte-wide register port gives access to a mode register, a transmit data register and a receive data register. The mode register selects the serial clock's resting level, the clock edge on which outgoing data changes, and the bit order. Its low three bits are a live read-only count of the bits still to be moved in the current frame.

Writing the transmit register while the engine is idle starts a frame. The frame has sixteen serial clock edges, and each half-period lasts `DIV` system clocks. Edges are numbered from 1 at the start of the frame, so edges 1, 3, … are odd and edges 2, 4, … are even. When the eighth bit has been sampled, the received byte is stored in the receive register and a done flag rises. Reading the receive register clears the flag. A new mode can be written during a frame: it becomes visible on readback at once but governs only the next frame.

The sequencer has three states:
- `ST_IDLE`: no frame is running.
- `ST_LEAD`: the serial clock is at its resting level.
- `ST_TRAIL`: the serial clock is at the opposite level.

The transitions are:
- START: `ST_IDLE` to `ST_LEAD`, on a transmit write.
- ODD EDGE: `ST_LEAD` to `ST_TRAIL`, on a divider tick.
- EVEN EDGE: `ST_TRAIL` to `ST_LEAD`, on a tick before the last bit pair.
- FINISH: `ST_TRAIL` to `ST_IDLE`, on the tick that closes the eighth pair.

Top module: `sync_shift_engine`

## Requirements
- R1: After reset, the mode register reads 8'h18. The done flag is 0, and both serial clock and serial data out are 1.
- R2: Mode bit 7 sets the clock polarity. When it is 0, the serial clock rests at 1 while no frame runs. When it is 1, the clock rests at 0.
- R3: With mode bit 6 = 0, the first bit is on serial data out from the frame start. Data out changes on odd edges 3 to 15, and serial data in is sampled on the even edges.
- R4: With mode bit 6 = 1, the first bit is on serial data out from the frame start. Data in is sampled on the odd edges, and data out changes on even edges 2 to 14.
- R5: Mode bit 5 sets the bit order. When it is 0, bits are transmitted and received most significant first. When it is 1, least significant first.
- R6: Mode bits 2:0 read the bits remaining. The value is 000 while idle and at the frame start (eight bits left), and it drops by one, modulo 8, after each sampled bit (111 means seven left, 001 means one left).
- R7: Mode bits 4 and 3 always read 1. Writes to mode bits 4:0 have no effect (writing 8'hFF reads back 8'hF8 when idle).
- R8: A transmit write (address 1) starts a frame only when the engine is idle. A transmit write during a frame changes neither the data out nor the received byte.
- R9: At frame end, the received byte is readable at address 2 and the done flag is 1. Reading address 2 clears the flag.
- R10: A mode write during a frame is read back at once, but the running frame keeps the clock level, phase and order it started with. The new values apply from the next idle period and the next frame.
- R11: Each serial clock half-period lasts DIV system clocks, so a frame takes 16·DIV cycles from the transmit write to the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done on address 2) |
| reg_addr | input | 2 | 0 mode, 1 transmit data, 2 receive data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sclk_o | output | 1 | Serial clock out |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| done_o | output | 1 | Frame-complete flag |

## Verification
Some properties are checked on every cycle:
- The sequencer moves only on divider ticks, and ticks are never back to back.
- The remaining-bit count falls by exactly one per sample and is zero whenever idle.
- The frame's active mode never changes while a frame is running.
- The done flag follows every finish.

Only the bench's scenarios can show the following:
- The actual bit order on the wire and the sample edge chosen by each phase and polarity combination.
- That the received byte matches what the far end sent.
- That transmit writes in mid-frame are ignored.
- That a mode written mid-frame takes effect in the following frame.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } ssx_state_e;

    typedef struct packed {
        logic pol;   // 0: clock rests high
        logic pha;   // 0: sample on even edges
        logic lsb;   // 1: least significant bit first
    } ssx_cfg_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_TX   = 2'd1;
    localparam logic [1:0] A_RX   = 2'd2;

endpackage

// File: rtl/ssx_tick.sv
module ssx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DW'(1);
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            // half-periods last more than one cycle
            assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ssx_fsm.sv
module ssx_fsm #(
    parameter int BITS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   tick,
    input  logic                   pha,
    output ssx_pkg::ssx_state_e    state_o,
    output logic                   sample_o,
    output logic                   change_o,
    output logic                   finish_o
);
    import ssx_pkg::*;

    localparam int PW = $clog2(BITS);

    ssx_state_e    state_q, state_d;
    logic [PW-1:0] pairs_q;
    logic          odd_edge, even_edge, last_pair;

    assign last_pair = (pairs_q == PW'(BITS - 1));
    assign state_o   = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = last_pair ? ST_IDLE : ST_LEAD;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pairs_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                pairs_q <= '0;
            end else if (even_edge && !last_pair) begin
                pairs_q <= pairs_q + PW'(1);
            end
        end
    end

    always_comb begin
        odd_edge  = (state_q == ST_LEAD)  && tick;
        even_edge = (state_q == ST_TRAIL) && tick;
        sample_o  = pha ? odd_edge : even_edge;
        change_o  = pha ? (even_edge && !last_pair) : (odd_edge && (pairs_q != '0));
        finish_o  = even_edge && last_pair;
    end

    // state may only advance on a divider tick once a frame runs
    assert_move_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && !tick |=> state_q == $past(state_q));

    assert_finish_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> state_q == ST_IDLE);

endmodule

// File: rtl/ssx_shift.sv
module ssx_shift #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [W-1:0]         tx_byte,
    input  logic                 shift_out,
    input  logic                 sample,
    input  logic                 sdi,
    input  logic                 lsb,
    output logic                 sdo_bit,
    output logic [W-1:0]         rx_next,
    output logic [$clog2(W)-1:0] cnt
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  txsh_q, rxsh_q;
    logic [CW-1:0] cnt_q;

    assign sdo_bit = lsb ? txsh_q[0] : txsh_q[W-1];
    assign cnt     = cnt_q;

    always_comb begin
        rx_next = rxsh_q;
        if (sample) begin
            rx_next = lsb ? {sdi, rxsh_q[W-1:1]} : {rxsh_q[W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsh_q <= '0;
            rxsh_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            txsh_q <= tx_byte;
            rxsh_q <= '0;
            cnt_q  <= '0;
        end else begin
            rxsh_q <= rx_next;
            if (shift_out) begin
                txsh_q <= lsb ? {1'b0, txsh_q[W-1:1]} : {txsh_q[W-2:0], 1'b0};
            end
            if (sample) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample && !load |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/sync_shift_engine.sv
module sync_shift_engine #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sclk_o,
    output logic       sdo_o,
    input  logic       sdi_i,
    output logic       done_o
);
    import ssx_pkg::*;

    localparam int W  = 8;
    localparam int CW = $clog2(W);

    ssx_state_e    state;
    ssx_cfg_t      pend_q, act_q, cfg_v;
    logic [W-1:0]  rx_q, rx_next;
    logic          done_q;
    logic          start, tick, sample, change, finish, sdo_bit;
    logic [CW-1:0] cnt;

    assign start = reg_wr && (reg_addr == A_TX) && (state == ST_IDLE);

    ssx_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .tick  (tick)
    );

    ssx_fsm #(.BITS(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .pha      (act_q.pha),
        .state_o  (state),
        .sample_o (sample),
        .change_o (change),
        .finish_o (finish)
    );

    ssx_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .tx_byte   (reg_wdata),
        .shift_out (change),
        .sample    (sample),
        .sdi       (sdi_i),
        .lsb       (act_q.lsb),
        .sdo_bit   (sdo_bit),
        .rx_next   (rx_next),
        .cnt       (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == A_MODE)) begin
                pend_q <= ssx_cfg_t'(reg_wdata[7:5]);
            end
            if (start) begin
                act_q <= pend_q;
            end
            if (finish) begin
                rx_q   <= rx_next;
                done_q <= 1'b1;
            end else if (reg_rd && (reg_addr == A_RX)) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_v  = (state == ST_IDLE) ? pend_q : act_q;
        sclk_o = ~cfg_v.pol ^ (state == ST_TRAIL);
        sdo_o  = (state == ST_IDLE) ? 1'b1 : sdo_bit;
        done_o = done_q;
        unique case (reg_addr)
            A_MODE:  reg_rdata = {pend_q, 2'b11, cnt};
            A_RX:    reg_rdata = rx_q;
            default: reg_rdata = '0;
        endcase
    end

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE) || $stable(act_q));

    assert_done_after_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q);

    assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));

endmodule

// File: tb/sync_shift_engine_bench.sv
module sync_shift_engine_bench;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, sdi_i = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sclk_o, sdo_o, done_o;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sync_shift_engine #(.DIV(DIV)) u_sync_shift_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .done_o(done_o)
    );

    // behavioural reference model
    bit         m_busy, m_half, m_done, was_busy;
    int         m_div, m_pairs, m_outi, m_cnt;
    logic [2:0] m_pend, m_act, pend_old;
    logic [7:0] m_tx, m_rx, m_slave;
    bit         m_q[$];

    function automatic logic [7:0] assemble(logic lsb);
        logic [7:0] v = 8'h00;
        foreach (m_q[i]) v = lsb ? {m_q[i], v[7:1]} : {v[6:0], m_q[i]};
        return v;
    endfunction

    task automatic take_sample();
        m_q.push_back(sdi_i);
        m_cnt = (m_cnt + 7) % 8;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_half = 0; m_done = 0; m_div = 0; m_pairs = 0;
            m_outi = 0; m_cnt = 0; m_pend = 3'b000; m_act = 3'b000;
            m_tx = 8'h00; m_rx = 8'h00; m_q.delete();
        end else begin
            pend_old = m_pend;
            was_busy = m_busy;
            if (reg_rd && reg_addr == 2'd2) m_done = 0;
            if (was_busy) begin
                m_div++;
                if (m_div == DIV) begin
                    m_div = 0;
                    if (!m_half) begin
                        if (m_act[1]) take_sample(); else if (m_pairs >= 1) m_outi++;
                        m_half = 1;
                    end else begin
                        if (!m_act[1]) take_sample(); else if (m_pairs <= 6) m_outi++;
                        if (m_pairs == 7) begin
                            m_busy = 0;
                            m_rx = assemble(m_act[0]);
                            m_done = 1;
                        end else begin
                            m_pairs++;
                        end
                        m_half = 0;
                    end
                end
            end
            if (reg_wr && reg_addr == 2'd0) m_pend = reg_wdata[7:5];
            if (reg_wr && reg_addr == 2'd1 && !was_busy) begin
                m_busy = 1; m_act = pend_old; m_tx = reg_wdata; m_outi = 0;
                m_div = 0; m_half = 0; m_pairs = 0; m_cnt = 0; m_q.delete();
            end
        end
    end

    // compare on every clock, away from the edge; then drive the far end's bit
    logic       e_sclk, e_sdo;
    logic [7:0] e_rdata;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            e_sclk = m_busy ? (!m_act[2] ^ m_half) : !m_pend[2];
            e_sdo  = m_busy ? m_tx[m_act[0] ? m_outi : 7 - m_outi] : 1'b1;
            case (reg_addr)
                2'd0:    e_rdata = {m_pend, 2'b11, 3'(m_cnt)};
                2'd2:    e_rdata = m_rx;
                default: e_rdata = 8'h00;
            endcase
            vectors++;
            if (sclk_o !== e_sclk || sdo_o !== e_sdo || done_o !== 1'(m_done)
                || reg_rdata !== e_rdata) begin
                miscompares++;
                $display("FAIL %s cycle compare: sclk %b/%b sdo %b/%b done %b/%b rdata %h/%h (actual/expected)",
                         cur_req, sclk_o, e_sclk, sdo_o, e_sdo, done_o, m_done, reg_rdata, e_rdata);
            end
        end
        if (m_busy && m_q.size() < 8)
            sdi_i = m_slave[m_act[0] ? m_q.size() : 7 - m_q.size()];
        else
            sdi_i = 1'b0;
    end

    task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_rx();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2;
        @(negedge clk); reg_rd = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #3; v = reg_rdata;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_o && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic frame(string req, logic [7:0] mode, logic [7:0] tx, logic [7:0] slv);
        int n;
        logic [7:0] v;
        cur_req = req;
        wr(2'd0, mode);
        m_slave = slv;
        wr(2'd1, tx);
        wait_done(n);
        chk("R11", "frame length in cycles", 8'(n), 8'(16 * DIV));
        chk("R9", "done after frame", {7'd0, done_o}, 8'h01);
        peek(2'd2, v);
        chk(req, "received byte", v, slv);
        rd_rx();
        #3 chk("R9", "done cleared by read", {7'd0, done_o}, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(2'd0, v);
        chk("R1", "mode after reset", v, 8'h18);
        chk("R1", "idle lines after reset", {5'd0, sclk_o, sdo_o, done_o}, 8'h06);

        cur_req = "R7";
        wr(2'd0, 8'hFF);
        peek(2'd0, v);
        chk("R7", "mode readback of FF", v, 8'hF8);
        wr(2'd0, 8'h07);
        peek(2'd0, v);
        chk("R7", "mode readback of 07", v, 8'h18);

        cur_req = "R2";
        wr(2'd0, 8'h80);
        #3 chk("R2", "clock rests low with polarity 1", {7'd0, sclk_o}, 8'h00);
        wr(2'd0, 8'h10);
        #3 chk("R2", "clock rests high with polarity 0", {7'd0, sclk_o}, 8'h01);

        frame("R3", 8'h10, 8'hA5, 8'h3C);
        frame("R4", 8'hF0, 8'h96, 8'h5A);
        frame("R4", 8'h50, 8'h81, 8'h7E);
        frame("R5", 8'hB0, 8'h1E, 8'hE1);
        frame("R5", 8'h30, 8'hC8, 8'h13);

        // mid-frame count and held writes
        cur_req = "R6";
        wr(2'd0, 8'h10);
        m_slave = 8'hC3;
        wr(2'd1, 8'h5B);
        repeat (3 * DIV) @(negedge clk);
        peek(2'd0, v);
        chk("R6", "count after first samples", {5'd0, v[2:0]}, 8'(m_cnt));
        cur_req = "R10";
        wr(2'd0, 8'hF0);
        peek(2'd0, v);
        chk("R10", "mid-frame mode readback", {5'd0, v[7:5]}, 8'h07);
        cur_req = "R8";
        wr(2'd1, 8'hFF);
        wait_done(n);
        peek(2'd2, v);
        chk("R8", "received byte unaffected by busy write", v, 8'hC3);
        rd_rx();
        #3 chk("R10", "new polarity applies when idle", {7'd0, sclk_o}, 8'h00);
        cur_req = "R10";
        m_slave = 8'h69;
        wr(2'd1, 8'h2D);
        wait_done(n);
        peek(2'd2, v);
        chk("R10", "next frame uses held mode", v, 8'h69);
        rd_rx();
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule